// File: doc/BRIEF.md
# Dual countdown timer

A pair of identical programmable down-counters behind one register decoder. Each counter works in one of three modes. In free-running mode it wraps at the maximum of its selected width. In periodic mode it reloads from a programmed period. In one-shot mode it stops itself at zero. Counting advances on an external tick-enable input that a per-counter prescaler can divide by 16 or 256.

Each counter raises a level interrupt flag when it reaches zero. The flag stays set until software writes the clear register. A per-counter enable masks the flag onto the shared interrupt output, which is the OR of both counters.

The register bus is a plain single-cycle port. A write takes effect on the clock edge where `bus_wr` is high. Read data is a combinational function of `bus_addr`.

Top module: `dual_countdown_timer`

## Requirements
- R1: After reset each counter's control reads 0x40 (interrupt enable only, stopped, free-running, 16-bit, no prescale), and its count, load value and raw flag all read 0. `irq_o` is low.
- R2: Per-counter byte offsets are 0x00 load (read/write), 0x04 count (read-only), 0x08 control (read/write), 0x0C flag clear (write-only, reads 0), 0x10 raw flag (bit 0), 0x14 masked flag (bit 0). Offsets 0x18 and 0x1C read 0 and ignore writes. Control bits are: 0 run, 1 periodic, 2 one-shot, 3 wide (32-bit), 5:4 prescale, 6 interrupt enable.
- R3: With both periodic and one-shot clear, the counter is free-running and ignores the load value. Its limit is 0xFFFFFFFF when wide is set and 0xFFFF when wide is clear. A zero event wraps the counter to that limit.
- R4: In periodic or one-shot mode the limit is the load value, masked to its low 16 bits when wide is clear. A load write puts the resulting limit into the counter.
- R5: A control write with run set loads the counter from the limit under the new control value and restarts the prescaler. With run clear, the count holds its value.
- R6: Each divided tick while running decrements the count. A tick that finds a count of 1 or 0 is a zero event. No counting happens while run is clear, while `tick_in` is low, or in the cycle of a load or control write.
- R7: In periodic mode a zero event sets the raw flag and reloads the limit.
- R8: In one-shot mode (which wins over periodic) a zero event sets the raw flag, leaves the count at 0 and clears the run bit.
- R9: Prescale 0 and 3 count every `tick_in` pulse. Prescale 1 counts every 16th pulse and prescale 2 every 256th, counted from the last control or load write.
- R10: Any write to the clear offset clears the raw flag. A zero event in the same cycle wins, and the flag stays set.
- R11: The masked flag is the raw flag when interrupt enable is set and 0 otherwise. `irq_o` is the OR of both masked flags.
- R12: With wide clear, count reads return 0 in bits 31:16.
- R13: Addresses 0x00–0x1F reach the first counter and 0x20–0x3F reach the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_in | input | 1 | Base-rate count enable |
| bus_addr | input | 6 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_o | output | 1 | OR of both masked flags |

## Verification
A zero event and a write to the clear offset can land on the same edge. The bench provokes this by running a periodic period of 3 with a divide of 1. It issues one clear on a non-event edge and expects the flag to drop. It issues a second clear timed onto the edge where the count leaves 1, and then expects the raw flag and `irq_o` to stay high. A control or load write can also land on a divided tick; the count must take the reloaded limit with no decrement, which the vector table checks after such writes.

// File: rtl/timer_pkg.sv
// Shared constants for the dual countdown timer: register offsets within
// one counter window and control bit positions. Assumes 32-bit data.
package timer_pkg;
    localparam int OFF_LOAD  = 'h00;
    localparam int OFF_COUNT = 'h04;
    localparam int OFF_CTRL  = 'h08;
    localparam int OFF_CLR   = 'h0C;
    localparam int OFF_RAW   = 'h10;
    localparam int OFF_MASK  = 'h14;

    localparam int CB_RUN    = 0;
    localparam int CB_PER    = 1;
    localparam int CB_ONE    = 2;
    localparam int CB_WIDE   = 3;
    localparam int CB_PS_LO  = 4;
    localparam int CB_IE     = 6;
    localparam int CTRL_W    = 7;

    localparam logic [1:0] PS_DIV_LO = 2'd1;
    localparam logic [1:0] PS_DIV_HI = 2'd2;
endpackage

// File: rtl/timer_prescaler.sv
// Divides the base tick enable by 1, 2**DIV_LO_LOG2 or 2**DIV_HI_LOG2.
// Assumes restart is pulsed in the same cycle as any change of sel.
module timer_prescaler
    import timer_pkg::*;
#(
    parameter int DIV_LO_LOG2 = 4,
    parameter int DIV_HI_LOG2 = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       tick_in,
    input  logic [1:0] sel,
    output logic       tick_out
);
    localparam int PRE_W = DIV_HI_LOG2;
    localparam logic [PRE_W-1:0] TERM_LO = PRE_W'((1 << DIV_LO_LOG2) - 1);
    localparam logic [PRE_W-1:0] TERM_HI = '1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] term;

    // Terminal value of the divider for the selected ratio.
    always_comb begin
        case (sel)
            PS_DIV_LO: term = TERM_LO;
            PS_DIV_HI: term = TERM_HI;
            default:   term = '0;
        endcase
    end

    assign tick_out = tick_in && (pre_q == term);

    // Count base ticks, wrapping at the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pre_q <= '0;
        end else if (tick_in) begin
            pre_q <= (pre_q == term) ? '0 : pre_q + 1'b1;
        end
    end

    AST_DIV_LO_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_out && !restart && sel == PS_DIV_LO) |=> !tick_out); // R9
endmodule

// File: rtl/timer_core.sv
// One countdown counter with its register window. Reads are combinational
// on offs. Writes land on the clock edge with wr_en high. The flag output
// is the masked interrupt level.
module timer_core
    import timer_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int NARROW_W    = 16,
    parameter int SLOT_W      = 5,
    parameter int DIV_LO_LOG2 = 4,
    parameter int DIV_HI_LOG2 = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic [SLOT_W-1:0] offs,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_o
);
    localparam logic [SLOT_W-1:0] A_LOAD  = SLOT_W'(OFF_LOAD);
    localparam logic [SLOT_W-1:0] A_COUNT = SLOT_W'(OFF_COUNT);
    localparam logic [SLOT_W-1:0] A_CTRL  = SLOT_W'(OFF_CTRL);
    localparam logic [SLOT_W-1:0] A_CLR   = SLOT_W'(OFF_CLR);
    localparam logic [SLOT_W-1:0] A_RAW   = SLOT_W'(OFF_RAW);
    localparam logic [SLOT_W-1:0] A_MASK  = SLOT_W'(OFF_MASK);
    localparam logic [DATA_W-1:0] WIDE_MAX   = '1;
    localparam logic [DATA_W-1:0] NARROW_MAX =
        {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    logic              run_q, per_q, one_q, wide_q, ie_q, raw_q;
    logic [1:0]        ps_q;
    logic [DATA_W-1:0] load_q, cnt_q;
    logic [DATA_W-1:0] cnt_vis, cur_limit, new_ctrl_limit, new_load_limit;
    logic              wr_load, wr_ctrl, wr_clr, cfg_wr;
    logic              div_tick, step, zero_hit;

    // Limit that a given mode, width and load value imply.
    function automatic logic [DATA_W-1:0] pick_limit(
        input logic per, input logic one, input logic wide,
        input logic [DATA_W-1:0] ld);
        if (per || one) begin
            pick_limit = wide ? ld : (ld & NARROW_MAX);
        end else begin
            pick_limit = wide ? WIDE_MAX : NARROW_MAX;
        end
    endfunction

    assign wr_load = wr_en && (offs == A_LOAD);
    assign wr_ctrl = wr_en && (offs == A_CTRL);
    assign wr_clr  = wr_en && (offs == A_CLR);
    assign cfg_wr  = wr_load || wr_ctrl;

    assign cnt_vis        = wide_q ? cnt_q : (cnt_q & NARROW_MAX);
    assign cur_limit      = pick_limit(per_q, one_q, wide_q, load_q);
    assign new_ctrl_limit = pick_limit(wdata[CB_PER], wdata[CB_ONE],
                                       wdata[CB_WIDE], load_q);
    assign new_load_limit = pick_limit(per_q, one_q, wide_q, wdata);

    timer_prescaler #(
        .DIV_LO_LOG2(DIV_LO_LOG2),
        .DIV_HI_LOG2(DIV_HI_LOG2)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cfg_wr),
        .tick_in (tick_in),
        .sel     (ps_q),
        .tick_out(div_tick)
    );

    assign step     = div_tick && run_q && !cfg_wr;
    assign zero_hit = step && (cnt_vis <= DATA_W'(1));

    // Control, load and counter state: register writes first, then counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            per_q  <= 1'b0;
            one_q  <= 1'b0;
            wide_q <= 1'b0;
            ps_q   <= 2'd0;
            ie_q   <= 1'b1;
            load_q <= '0;
            cnt_q  <= '0;
        end else if (wr_ctrl) begin
            run_q  <= wdata[CB_RUN];
            per_q  <= wdata[CB_PER];
            one_q  <= wdata[CB_ONE];
            wide_q <= wdata[CB_WIDE];
            ps_q   <= wdata[CB_PS_LO +: 2];
            ie_q   <= wdata[CB_IE];
            if (wdata[CB_RUN]) begin
                cnt_q <= new_ctrl_limit;
            end
        end else if (wr_load) begin
            load_q <= wdata;
            cnt_q  <= new_load_limit;
        end else if (zero_hit) begin
            if (one_q) begin
                cnt_q <= '0;
                run_q <= 1'b0;
            end else begin
                cnt_q <= cur_limit;
            end
        end else if (step) begin
            cnt_q <= cnt_vis - 1'b1;
        end
    end

    // Raw flag: a zero event outranks a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= 1'b0;
        end else if (zero_hit) begin
            raw_q <= 1'b1;
        end else if (wr_clr) begin
            raw_q <= 1'b0;
        end
    end

    assign irq_o = raw_q && ie_q;

    // Read mux over the counter window; unmapped offsets return zero.
    always_comb begin
        rdata = '0;
        case (offs)
            A_LOAD:  rdata = load_q;
            A_COUNT: rdata = cnt_vis;
            A_CTRL:  rdata = DATA_W'({ie_q, ps_q, wide_q, one_q, per_q, run_q});
            A_RAW:   rdata = DATA_W'(raw_q);
            A_MASK:  rdata = DATA_W'(irq_o);
            default: rdata = '0;
        endcase
    end

    AST_ZERO_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        zero_hit |=> raw_q); // R10
    AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && !zero_hit) |=> !raw_q); // R10
    AST_ONESHOT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_hit && one_q) |=> (!run_q && cnt_vis == '0)); // R8
    AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_hit && per_q && !one_q) |=> (cnt_vis == $past(cur_limit))); // R7
    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !cfg_wr) |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/dual_countdown_timer.sv
// Top: decodes the bus into NUM_TIMERS windows of 2**SLOT_W bytes and ORs
// the masked flags onto one interrupt. Addresses past the last window
// read zero and ignore writes.
module dual_countdown_timer
    import timer_pkg::*;
#(
    parameter int NUM_TIMERS  = 2,
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 32,
    parameter int NARROW_W    = 16,
    parameter int SLOT_W      = 5,
    parameter int DIV_LO_LOG2 = 4,
    parameter int DIV_HI_LOG2 = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    logic [NUM_TIMERS-1:0] hit;
    logic [NUM_TIMERS-1:0] irq_vec;
    logic [DATA_W-1:0]     rd_vec [NUM_TIMERS];

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
        assign hit[g] = ((bus_addr >> SLOT_W) == ADDR_W'(g));

        timer_core #(
            .DATA_W     (DATA_W),
            .NARROW_W   (NARROW_W),
            .SLOT_W     (SLOT_W),
            .DIV_LO_LOG2(DIV_LO_LOG2),
            .DIV_HI_LOG2(DIV_HI_LOG2)
        ) u_core (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_in(tick_in),
            .offs   (bus_addr[SLOT_W-1:0]),
            .wr_en  (bus_wr && hit[g]),
            .wdata  (bus_wdata),
            .rdata  (rd_vec[g]),
            .irq_o  (irq_vec[g])
        );
    end

    // Return the selected window's read data.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_TIMERS; i++) begin
            if (hit[i]) begin
                bus_rdata = bus_rdata | rd_vec[i];
            end
        end
    end

    assign irq_o = |irq_vec;

    AST_ONE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit)); // R13
endmodule

// File: tb/dual_countdown_timer_tb.sv
module dual_countdown_timer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 28;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_in = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    int          n_chk = 0;
    int          n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_countdown_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o)
    );

    // {write addr, write data, idle cycles, read addr, expected, requirement}
    localparam logic [87:0] VECS [NV] = '{
        {6'h00, 32'h5,        4'd0, 6'h04, 32'h0000FFFF, 8'd3},  // R3 free run ignores load
        {6'h08, 32'h43,       4'd0, 6'h04, 32'h5,        8'd5},  // R5 run reloads
        {6'h18, 32'hFFFFFFFF, 4'd0, 6'h18, 32'h0,        8'd2},  // R2 unmapped
        {6'h0C, 32'h0,        4'd0, 6'h04, 32'h1,        8'd6},  // R6 decrement
        {6'h1C, 32'h0,        4'd0, 6'h10, 32'h1,        8'd7},  // R7 periodic event
        {6'h0C, 32'h0,        4'd0, 6'h10, 32'h0,        8'd10}, // R10 clear
        {6'h08, 32'h3,        4'd3, 6'h04, 32'h2,        8'd5},  // R5 restart
        {6'h18, 32'h0,        4'd3, 6'h14, 32'h0,        8'd11}, // R11 masked off
        {6'h1C, 32'h0,        4'd0, 6'h10, 32'h1,        8'd7},  // R7
        {6'h08, 32'h45,       4'd0, 6'h04, 32'h5,        8'd8},  // R8 one-shot start
        {6'h0C, 32'h0,        4'd0, 6'h14, 32'h0,        8'd10}, // R10
        {6'h18, 32'h0,        4'd5, 6'h08, 32'h44,       8'd8},  // R8 run cleared
        {6'h18, 32'h0,        4'd0, 6'h04, 32'h0,        8'd8},  // R8 count stays 0
        {6'h1C, 32'h0,        4'd0, 6'h14, 32'h1,        8'd11}, // R11 masked on
        {6'h08, 32'h8,        4'd0, 6'h04, 32'h0,        8'd5},  // R5 stopped holds
        {6'h00, 32'h12345,    4'd0, 6'h04, 32'hFFFFFFFF, 8'd3},  // R3 wide limit
        {6'h08, 32'h3,        4'd0, 6'h04, 32'h2345,     8'd4},  // R4 narrow mask
        {6'h0C, 32'h0,        4'd0, 6'h10, 32'h0,        8'd10}, // R10
        {6'h08, 32'h9,        4'd2, 6'h04, 32'hFFFFFFFD, 8'd6},  // R6 wide count
        {6'h08, 32'h1,        4'd0, 6'h04, 32'h0000FFFF, 8'd12}, // R12 narrow read
        {6'h08, 32'h0,        4'd0, 6'h04, 32'h0000FFFE, 8'd5},  // R5
        {6'h20, 32'h3,        4'd0, 6'h24, 32'h0000FFFF, 8'd13}, // R13 second window
        {6'h28, 32'h43,       4'd3, 6'h30, 32'h1,        8'd13}, // R13
        {6'h3C, 32'h0,        4'd0, 6'h10, 32'h0,        8'd13}, // R13 first untouched
        {6'h28, 32'h40,       4'd0, 6'h34, 32'h1,        8'd11}, // R11
        {6'h2C, 32'h0,        4'd0, 6'h34, 32'h0,        8'd10}, // R10
        {6'h00, 32'h7,        4'd0, 6'h0C, 32'h0,        8'd2},  // R2 clear reads 0
        {6'h18, 32'h0,        4'd0, 6'h00, 32'h7,        8'd2}   // R2 load readback
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic write_reg(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tick_in = 1'b1;
        bus_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R1 reset state
        check_rd(6'h08, 32'h40, "R1 ctrl");
        check_rd(6'h04, 32'h0,  "R1 count");
        check_rd(6'h00, 32'h0,  "R1 load");
        check_rd(6'h10, 32'h0,  "R1 raw");
        check_rd(6'h28, 32'h40, "R1 ctrl b");
        check("R1 irq", 32'(irq_o), 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [87:0] v;
            v = VECS[i];
            write_reg(v[87:82], v[81:50]);
            repeat (int'(v[49:46])) @(negedge clk);
            check_rd(v[45:40], v[39:8], $sformatf("R%0d vec%0d", v[7:0], i));
        end

        // R9 prescale ratios, including code 3
        for (int ps = 1; ps <= 3; ps++) begin
            int d;
            d = (ps == 1) ? 16 : (ps == 2) ? 256 : 1;
            do_reset();
            write_reg(6'h00, 32'd2);
            write_reg(6'h08, 32'h43 | (ps << 4));
            repeat (d - 1) @(negedge clk);
            check_rd(6'h04, 32'd2, $sformatf("R9 ps%0d before", ps));
            @(negedge clk);
            check_rd(6'h04, 32'd1, $sformatf("R9 ps%0d after", ps));
        end
        // R6 no counting with tick_in low
        tick_in = 1'b0;
        repeat (5) @(negedge clk);
        check_rd(6'h04, 32'd1, "R6 tick low holds");
        check_rd(6'h10, 32'd0, "R6 no event");
        tick_in = 1'b1;

        // R10 clear versus zero event on the same edge
        do_reset();
        write_reg(6'h00, 32'd3);
        write_reg(6'h08, 32'h43);
        repeat (2) @(negedge clk);
        write_reg(6'h0C, 32'h0);
        check_rd(6'h10, 32'd0, "R10 clear alone");
        check("R11 irq low", 32'(irq_o), 32'h0);
        write_reg(6'h0C, 32'h0);
        check_rd(6'h10, 32'd1, "R10 event wins");
        check("R10 irq kept", 32'(irq_o), 32'h1);

        // R11 interrupt from second counter only, then masked
        do_reset();
        write_reg(6'h20, 32'd1);
        write_reg(6'h28, 32'h43);
        @(negedge clk);
        check("R11 irq from b", 32'(irq_o), 32'h1);
        check_rd(6'h10, 32'd0, "R13 a raw clear");
        write_reg(6'h28, 32'h00);
        check("R11 irq masked", 32'(irq_o), 32'h0);
        check_rd(6'h30, 32'd1, "R11 b raw kept");

        finish_run();
    end
endmodule